// File: doc/BRIEF.md
# HDLC Receive Address Screen with Error Statistics

This block sits behind an HDLC receiver's deframer and in front of its buffer logic. It watches the byte stream of each received frame and reads the two bytes that follow the opening flag. It compares that 16-bit address word against a table of four programmable station addresses, using one shared bit mask. A frame that hits any table entry is passed downstream one byte at a time, with markers on its first and last bytes and a good-frame flag. A frame that misses is dropped without any output.

At the end of each frame the receiver gives a status strobe carrying three flags: a CRC error, a missing free buffer and an overrun. Abort sequences arrive as a separate pulse. From these, the block keeps four wrap-around 16-bit statistics counters:

- discarded frames,
- CRC errors,
- abort sequences,
- address misses.

Software may preset each counter, but only while the channel is disabled.

The core is a four-state frame tracker:

- **IDLE**: no frame is open.
- **ADDR2**: the first address byte has been stored and the second is awaited.
- **PASS**: the address hit and bytes are being forwarded.
- **DROP**: the address missed and bytes are swallowed.

Transitions:

- A start-of-frame byte moves the tracker from any state to ADDR2.
- The second byte moves ADDR2 to PASS on a hit, or to DROP on a miss.
- An end strobe, an abort pulse or a channel disable returns the tracker to IDLE.

Top module: `hdlc_addr_screen`

## Requirements
- R1: A frame hits when, for at least one of the four address entries, every address bit whose mask bit is 1 equals the entry bit; mask bits of 0 are don't-care. Entry i sits in bits 16i+15 down to 16i of `addr_tab`.
- R2: The first address byte after the flag is compared with bits 7:0 of an entry and the second with bits 15:8, so bytes 0x68 then 0xAA hit an entry of 0xAA68 under mask 0xFFFF.
- R3: With `addr_mask` = 0x00FF, the second address byte has no effect on the hit decision.
- R4: The bytes of a hitting frame appear on `out_data` in arrival order, address bytes included. Timing is as follows:
  - The first byte appears in the cycle after the second byte is accepted, with `out_first`.
  - Each later byte appears one input byte late.
  - The final byte appears in the cycle after the end strobe or abort pulse, with `out_last`.
  - A missing frame, or one that ends before its second byte, produces no output.
- R5: `out_ok` is 1 only with `out_last`, and only for a frame closed by an end strobe whose CRC-error, no-buffer and overrun flags are all 0.
- R6: An end strobe for a frame with no CRC error and no overrun that did not hit increments `cnt_nomatch`. This includes frames that ended before two address bytes arrived.
- R7: An end strobe for a hitting frame with no CRC error and no overrun but with the no-buffer flag increments `cnt_discard`.
- R8: An end strobe with the CRC-error flag and no overrun increments `cnt_crc`, whether the frame hit or missed and whatever the no-buffer flag is.
- R9: An end strobe with the overrun flag changes no counter.
- R10: Each `abort_det` pulse while enabled increments `cnt_abort` by one, inside or outside a frame. An abort ends the frame, and in the same cycle it overrides a coinciding end strobe or byte, which are then ignored.
- R11: Every counter wraps from 0xFFFF to 0x0000.
- R12: `cnt_wr_en` loads `cnt_wr_data` into the counter chosen by `cnt_wr_sel` only while `chan_en` is 0. The selection codes are 0 for discard, 1 for CRC, 2 for abort and 3 for nomatch. The load is ignored while `chan_en` is 1, and nothing counts while `chan_en` is 0.
- R13: After reset all counters are 0 and no output is valid. While `chan_en` is 0 no output is produced and the tracker returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; counters writable only when low |
| addr_tab | input | 64 | Four 16-bit station addresses, entry i at bits 16i+15:16i |
| addr_mask | input | 16 | Shared compare mask, 1 = bit compared |
| rx_valid | input | 1 | Received byte strobe |
| rx_sof | input | 1 | Marks the first byte after the opening flag |
| rx_data | input | 8 | Received byte |
| end_vld | input | 1 | End-of-frame status strobe |
| st_crc_err | input | 1 | Frame had a CRC error (with end_vld) |
| st_no_buf | input | 1 | No free buffer for the frame (with end_vld) |
| st_overrun | input | 1 | Frame suffered an overrun (with end_vld) |
| abort_det | input | 1 | Abort sequence detected |
| cnt_wr_en | input | 1 | Counter preset strobe |
| cnt_wr_sel | input | 2 | Counter to preset: 0 discard, 1 crc, 2 abort, 3 nomatch |
| cnt_wr_data | input | 16 | Preset value |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_first | output | 1 | First byte of a forwarded frame |
| out_last | output | 1 | Last byte of a forwarded frame |
| out_ok | output | 1 | Forwarded frame ended error-free with a buffer |
| cnt_discard | output | 16 | Discarded-frame counter |
| cnt_crc | output | 16 | CRC-error counter |
| cnt_abort | output | 16 | Abort-sequence counter |
| cnt_nomatch | output | 16 | Address-miss counter |

## Verification
The abort detector and the end-of-frame status strobe can fire in the same cycle, and the abort must win: only `cnt_abort` moves, and the forwarded frame closes with `out_ok` low. The bench provokes this directly by raising both at once, with a CRC error flagged, on a hitting frame. It also mixes random aborts in place of end strobes across many random frames. The result is judged by comparing all four counters and the forwarded byte record against a bench model that applies the abort-first priority.

// File: rtl/hdlc_scr_pkg.sv
package hdlc_scr_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ADDR2 = 2'd1,
        FS_PASS  = 2'd2,
        FS_DROP  = 2'd3
    } fstate_t;

    localparam int NUM_CNT = 4;

    typedef enum logic [1:0] {
        CNT_DISC    = 2'd0,
        CNT_CRC     = 2'd1,
        CNT_ABORT   = 2'd2,
        CNT_NOMATCH = 2'd3
    } cnt_sel_t;

endpackage

// File: rtl/hdlc_addr_match.sv
module hdlc_addr_match #(
    parameter int N_ADDR = 4,
    parameter int AW     = 16
) (
    input  logic [AW-1:0]        addr_word,
    input  logic [N_ADDR*AW-1:0] addr_tab,
    input  logic [AW-1:0]        addr_mask,
    output logic                 hit
);
    logic [N_ADDR-1:0] entry_hit;

    generate
        for (genvar g = 0; g < N_ADDR; g++) begin : g_entry
            logic [AW-1:0] diff;
            assign diff         = (addr_word ^ addr_tab[g*AW +: AW]) & addr_mask;
            assign entry_hit[g] = (diff == '0);
        end
    endgenerate

    assign hit = |entry_hit;
endmodule

// File: rtl/hdlc_stat_bank.sv
module hdlc_stat_bank #(
    parameter int CNT_W = 16,
    parameter int NUM   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   chan_en,
    input  logic [NUM-1:0]         inc,
    input  logic                   wr_en,
    input  logic [$clog2(NUM)-1:0] wr_sel,
    input  logic [CNT_W-1:0]       wr_data,
    output logic [NUM*CNT_W-1:0]   cnt_flat
);
    localparam int SW = $clog2(NUM);

    logic wr_ok;
    assign wr_ok = wr_en & ~chan_en;

    generate
        for (genvar g = 0; g < NUM; g++) begin : g_cnt
            logic [CNT_W-1:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (wr_ok && (wr_sel == SW'(g))) begin
                    val_q <= wr_data;
                end else if (chan_en && inc[g]) begin
                    val_q <= val_q + 1'b1;
                end
            end
            assign cnt_flat[g*CNT_W +: CNT_W] = val_q;
        end
    endgenerate
endmodule

// File: rtl/hdlc_frame_ctl.sv
module hdlc_frame_ctl
    import hdlc_scr_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic [BW-1:0] rx_data,
    input  logic          end_vld,
    input  logic          st_crc_err,
    input  logic          st_no_buf,
    input  logic          st_overrun,
    input  logic          abort_det,
    input  logic          hit,
    output logic [BW-1:0] lo_byte,
    output logic          inc_disc,
    output logic          inc_crc,
    output logic          inc_abort,
    output logic          inc_nomatch,
    output logic          out_valid,
    output logic [BW-1:0] out_data,
    output logic          out_first,
    output logic          out_last,
    output logic          out_ok
);
    fstate_t       st_q, st_d;
    logic [BW-1:0] lo_q, pend_q;
    logic          ev_abort, ev_end, ev_byte, ev_sof, ev_cont;
    logic          err_free, matched;

    // event decode: abort beats end strobe beats byte
    always_comb begin
        ev_abort = chan_en & abort_det;
        ev_end   = chan_en & ~abort_det & end_vld & (st_q != FS_IDLE);
        ev_byte  = chan_en & ~abort_det & ~end_vld & rx_valid;
        ev_sof   = ev_byte & rx_sof;
        ev_cont  = ev_byte & ~rx_sof;
        err_free = ~st_crc_err & ~st_overrun;
        matched  = (st_q == FS_PASS);
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!chan_en || ev_abort || ev_end) begin
            st_d = FS_IDLE;
        end else if (ev_sof) begin
            st_d = FS_ADDR2;
        end else if (ev_cont) begin
            unique case (st_q)
                FS_IDLE:  st_d = FS_IDLE;
                FS_ADDR2: st_d = hit ? FS_PASS : FS_DROP;
                FS_PASS:  st_d = FS_PASS;
                FS_DROP:  st_d = FS_DROP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_d;
    end

    // statistics events
    always_comb begin
        inc_abort   = ev_abort;
        inc_crc     = ev_end & st_crc_err & ~st_overrun;
        inc_nomatch = ev_end & err_free & ~matched;
        inc_disc    = ev_end & err_free & matched & st_no_buf;
    end

    // forwarding datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q      <= '0;
            pend_q    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            out_ok    <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            out_ok    <= 1'b0;
            if (ev_sof) begin
                lo_q <= rx_data;
            end
            unique case (st_q)
                FS_IDLE, FS_DROP: ;
                FS_ADDR2: begin
                    if (ev_cont && hit) begin
                        out_valid <= 1'b1;
                        out_first <= 1'b1;
                        out_data  <= lo_q;
                        pend_q    <= rx_data;
                    end
                end
                FS_PASS: begin
                    if (ev_abort) begin
                        out_valid <= 1'b1;
                        out_last  <= 1'b1;
                        out_data  <= pend_q;
                    end else if (ev_end) begin
                        out_valid <= 1'b1;
                        out_last  <= 1'b1;
                        out_ok    <= err_free & ~st_no_buf;
                        out_data  <= pend_q;
                    end else if (ev_cont) begin
                        out_valid <= 1'b1;
                        out_data  <= pend_q;
                        pend_q    <= rx_data;
                    end
                end
            endcase
        end
    end

    assign lo_byte = lo_q;
endmodule

// File: rtl/hdlc_addr_screen.sv
module hdlc_addr_screen
    import hdlc_scr_pkg::*;
#(
    parameter int N_ADDR = 4,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         chan_en,
    input  logic [N_ADDR*2*BYTE_W-1:0]   addr_tab,
    input  logic [2*BYTE_W-1:0]          addr_mask,
    input  logic                         rx_valid,
    input  logic                         rx_sof,
    input  logic [BYTE_W-1:0]            rx_data,
    input  logic                         end_vld,
    input  logic                         st_crc_err,
    input  logic                         st_no_buf,
    input  logic                         st_overrun,
    input  logic                         abort_det,
    input  logic                         cnt_wr_en,
    input  logic [1:0]                   cnt_wr_sel,
    input  logic [CNT_W-1:0]             cnt_wr_data,
    output logic                         out_valid,
    output logic [BYTE_W-1:0]            out_data,
    output logic                         out_first,
    output logic                         out_last,
    output logic                         out_ok,
    output logic [CNT_W-1:0]             cnt_discard,
    output logic [CNT_W-1:0]             cnt_crc,
    output logic [CNT_W-1:0]             cnt_abort,
    output logic [CNT_W-1:0]             cnt_nomatch
);
    localparam int AW = 2 * BYTE_W;

    logic [BYTE_W-1:0]        lo_byte;
    logic                     hit;
    logic [NUM_CNT-1:0]       inc_vec;
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;

    hdlc_addr_match #(.N_ADDR(N_ADDR), .AW(AW)) u_match (
        .addr_word (AW'({rx_data, lo_byte})),
        .addr_tab  (addr_tab),
        .addr_mask (addr_mask),
        .hit       (hit)
    );

    hdlc_frame_ctl #(.BW(BYTE_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_en     (chan_en),
        .rx_valid    (rx_valid),
        .rx_sof      (rx_sof),
        .rx_data     (rx_data),
        .end_vld     (end_vld),
        .st_crc_err  (st_crc_err),
        .st_no_buf   (st_no_buf),
        .st_overrun  (st_overrun),
        .abort_det   (abort_det),
        .hit         (hit),
        .lo_byte     (lo_byte),
        .inc_disc    (inc_vec[CNT_DISC]),
        .inc_crc     (inc_vec[CNT_CRC]),
        .inc_abort   (inc_vec[CNT_ABORT]),
        .inc_nomatch (inc_vec[CNT_NOMATCH]),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_first   (out_first),
        .out_last    (out_last),
        .out_ok      (out_ok)
    );

    hdlc_stat_bank #(.CNT_W(CNT_W), .NUM(NUM_CNT)) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_en  (chan_en),
        .inc      (inc_vec),
        .wr_en    (cnt_wr_en),
        .wr_sel   (cnt_wr_sel),
        .wr_data  (cnt_wr_data),
        .cnt_flat (cnt_flat)
    );

    assign cnt_discard = cnt_flat[CNT_DISC*CNT_W    +: CNT_W];
    assign cnt_crc     = cnt_flat[CNT_CRC*CNT_W     +: CNT_W];
    assign cnt_abort   = cnt_flat[CNT_ABORT*CNT_W   +: CNT_W];
    assign cnt_nomatch = cnt_flat[CNT_NOMATCH*CNT_W +: CNT_W];
endmodule

// File: rtl/hdlc_addr_screen_chk.sv
module hdlc_addr_screen_chk #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chan_en,
    input logic              end_vld,
    input logic              st_overrun,
    input logic              abort_det,
    input logic              cnt_wr_en,
    input logic              out_valid,
    input logic              out_first,
    input logic              out_last,
    input logic              out_ok,
    input logic [CNT_W-1:0]  cnt_discard,
    input logic [CNT_W-1:0]  cnt_crc,
    input logic [CNT_W-1:0]  cnt_abort,
    input logic [CNT_W-1:0]  cnt_nomatch
);
    // R10 / R11: one step per abort, wrapping
    a_r10_abort_step: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && abort_det) |=> (cnt_abort == CNT_W'($past(cnt_abort) + 1'b1)));

    // R9: overrun end strobe leaves the frame counters alone
    a_r9_overrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && end_vld && !abort_det && st_overrun)
        |=> ($stable(cnt_crc) && $stable(cnt_nomatch) && $stable(cnt_discard)));

    // R12: nothing counts while disabled unless preset
    a_r12_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && !cnt_wr_en)
        |=> ($stable(cnt_crc) && $stable(cnt_nomatch) && $stable(cnt_discard) && $stable(cnt_abort)));

    // R13: disabled channel produces no output
    a_r13_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !out_valid);

    // R5: good flag only on a final byte
    a_r5_ok_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_ok |-> (out_valid && out_last));

    // R4: markers only with valid, never both at once
    a_r4_markers: assert property (@(posedge clk) disable iff (!rst_n)
        (out_first || out_last) |-> (out_valid && !(out_first && out_last)));
endmodule

bind hdlc_addr_screen hdlc_addr_screen_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_hdlc_addr_screen.sv
`timescale 1ns/1ps
module sim_hdlc_addr_screen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic [63:0] addr_tab = '0;
    logic [15:0] addr_mask = '0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        end_vld = 1'b0, st_crc_err = 1'b0, st_no_buf = 1'b0, st_overrun = 1'b0;
    logic        abort_det = 1'b0;
    logic        cnt_wr_en = 1'b0;
    logic [1:0]  cnt_wr_sel = '0;
    logic [15:0] cnt_wr_data = '0;
    logic        out_valid, out_first, out_last, out_ok;
    logic [7:0]  out_data;
    logic [15:0] cnt_discard, cnt_crc, cnt_abort, cnt_nomatch;

    int checks = 0;
    int fails  = 0;
    logic [15:0] m_disc = 0, m_crc = 0, m_abort = 0, m_nom = 0;
    logic [7:0]  fb [0:31];
    logic [10:0] got [$];

    always #5 clk = ~clk;

    hdlc_addr_screen u0 (.*);

    always @(negedge clk) begin
        if (out_valid) got.push_back({out_first, out_last, out_ok, out_data});
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic bit model_hit(input logic [7:0] b0, input logic [7:0] b1);
        for (int i = 0; i < 4; i++)
            if (((({b1, b0}) ^ addr_tab[16*i +: 16]) & addr_mask) == 16'h0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_counters(input string req);
        chk(cnt_discard == m_disc,  {req, " discard"}, cnt_discard, m_disc);
        chk(cnt_crc     == m_crc,   {req, " crc"},     cnt_crc,     m_crc);
        chk(cnt_abort   == m_abort, {req, " abort"},   cnt_abort,   m_abort);
        chk(cnt_nomatch == m_nom,   {req, " nomatch"}, cnt_nomatch, m_nom);
    endtask

    // mode: 0 end strobe, 1 abort, 2 abort together with end strobe
    task automatic run_frame(input int len, input bit crc, input bit nobuf, input bit ovr,
                             input int mode, input string req);
        bit hitf, okf, errfree;
        hitf = (len >= 2) && model_hit(fb[0], fb[1]);
        errfree = !crc && !ovr;
        got.delete();
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_data = fb[i];
            tick();
        end
        rx_valid = 1'b0; rx_sof = 1'b0;
        if (mode != 0) abort_det = 1'b1;
        if (mode != 1) begin
            end_vld = 1'b1; st_crc_err = crc; st_no_buf = nobuf; st_overrun = ovr;
        end
        tick();
        abort_det = 1'b0; end_vld = 1'b0; st_crc_err = 1'b0; st_no_buf = 1'b0; st_overrun = 1'b0;
        tick(3);
        if (mode != 0) begin
            m_abort = m_abort + 1'b1;
            okf = 1'b0;
        end else begin
            okf = errfree && !nobuf;
            if (crc && !ovr) m_crc = m_crc + 1'b1;
            if (errfree && !hitf) m_nom = m_nom + 1'b1;
            if (errfree && hitf && nobuf) m_disc = m_disc + 1'b1;
        end
        chk(got.size() == (hitf ? len : 0), {req, " R4 byte count"}, got.size(), hitf ? len : 0);
        if (hitf && got.size() == len) begin
            for (int i = 0; i < len; i++) begin
                logic [10:0] e;
                e = {(i == 0), (i == len - 1), (i == len - 1) && okf, fb[i]};
                chk(got[i] == e, {req, " R4/R5 byte"}, got[i], e);
            end
        end
        check_counters(req);
    endtask

    task automatic preset(input logic [1:0] sel, input logic [15:0] val);
        cnt_wr_en = 1'b1; cnt_wr_sel = sel; cnt_wr_data = val;
        tick();
        cnt_wr_en = 1'b0;
        tick();
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4242);
        addr_tab = {16'h1234, 16'h5A3C, 16'h0F0F, 16'hAA68};
        addr_mask = 16'hFFFF;
        tick(3);
        // R13 reset state
        chk(!out_valid, "R13 reset out_valid", out_valid, 0);
        check_counters("R13 reset");
        rst_n = 1'b1;
        tick(2);
        chan_en = 1'b1;
        tick();

        // R2 byte order: 0x68 then 0xAA hits entry 0xAA68
        fb[0] = 8'h68; fb[1] = 8'hAA; fb[2] = 8'h11; fb[3] = 8'h22;
        run_frame(4, 0, 0, 0, 0, "R2 order");
        // R2 reversed order misses -> R6
        fb[0] = 8'hAA; fb[1] = 8'h68;
        run_frame(3, 0, 0, 0, 0, "R2/R6 reversed");
        // R1 masked don't-care bits
        addr_mask = 16'hFFF0;
        fb[0] = 8'h3F; fb[1] = 8'h5A; fb[2] = 8'h99;
        run_frame(3, 0, 0, 0, 0, "R1 mask dont-care");
        addr_mask = 16'hFFFF;
        run_frame(3, 0, 0, 0, 0, "R1 compared bit miss");
        // R3 8-bit addressing
        addr_mask = 16'h00FF;
        fb[0] = 8'h0F; fb[1] = 8'hE7; fb[2] = 8'h01;
        run_frame(3, 0, 0, 0, 0, "R3 eight bit");
        addr_mask = 16'hFFFF;
        // R6 short frame
        fb[0] = 8'h68;
        run_frame(1, 0, 0, 0, 0, "R6 short frame");
        // R7 discard on hit without buffer
        fb[0] = 8'h34; fb[1] = 8'h12; fb[2] = 8'h77;
        run_frame(3, 0, 1, 0, 0, "R7 discard");
        // R8 crc on hit and on miss
        run_frame(3, 1, 1, 0, 0, "R8 crc hit");
        fb[0] = 8'h00; fb[1] = 8'h00;
        run_frame(2, 1, 0, 0, 0, "R8 crc miss");
        // R9 overrun counts nothing
        run_frame(2, 1, 0, 1, 0, "R9 overrun miss");
        fb[0] = 8'h68; fb[1] = 8'hAA;
        run_frame(2, 0, 0, 1, 0, "R9 overrun hit");
        // R10 abort mid frame and abort together with end strobe
        fb[2] = 8'h5C;
        run_frame(3, 0, 0, 0, 1, "R10 abort");
        run_frame(3, 1, 0, 0, 2, "R10 abort with end");
        // R10 abort outside a frame
        abort_det = 1'b1; tick(); abort_det = 1'b0; tick(2);
        m_abort = m_abort + 1'b1;
        check_counters("R10 idle abort");

        // R12 preset while enabled ignored
        preset(2'd1, 16'h7777);
        check_counters("R12 write while enabled");
        // R12 preset while disabled, R11 wrap
        chan_en = 1'b0; tick();
        preset(2'd0, 16'hFFFF); preset(2'd1, 16'hFFFF);
        preset(2'd2, 16'hFFFF); preset(2'd3, 16'hFFFE);
        m_disc = 16'hFFFF; m_crc = 16'hFFFF; m_abort = 16'hFFFF; m_nom = 16'hFFFE;
        // R12 nothing counts while disabled; R13 no output
        got.delete();
        abort_det = 1'b1; tick(); abort_det = 1'b0;
        fb[0] = 8'h68; fb[1] = 8'hAA;
        rx_valid = 1'b1; rx_sof = 1'b1; rx_data = 8'h68; tick();
        rx_sof = 1'b0; rx_data = 8'hAA; tick(); rx_valid = 1'b0; tick(2);
        chk(got.size() == 0, "R13 disabled output", got.size(), 0);
        check_counters("R12 disabled preset");
        chan_en = 1'b1; tick();
        fb[0] = 8'h34; fb[1] = 8'h12;
        run_frame(2, 0, 1, 0, 0, "R11 wrap discard");
        run_frame(2, 1, 0, 0, 0, "R11 wrap crc");
        run_frame(2, 0, 0, 0, 1, "R11 wrap abort");
        fb[0] = 8'h01;
        run_frame(2, 0, 0, 0, 0, "R11 nomatch to FFFF");
        run_frame(2, 0, 0, 0, 0, "R11 wrap nomatch");

        // random frames
        addr_mask = 16'hF0FF;
        for (int n = 0; n < 300; n++) begin
            int len, mode, pick;
            bit c, b, o;
            len = 1 + int'($urandom % 12);
            pick = int'($urandom % 4);
            for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
            if ($urandom % 2 == 0) begin
                fb[0] = addr_tab[16*pick +: 8];
                if (len > 1) fb[1] = addr_tab[16*pick + 8 +: 8] ^ 8'($urandom % 2 == 0 ? 8'h00 : 8'h0C);
            end
            c = ($urandom % 5 == 0);
            b = ($urandom % 4 == 0);
            o = ($urandom % 7 == 0);
            mode = ($urandom % 8 == 0) ? 1 + int'($urandom % 2) : 0;
            run_frame(len, c, b, o, mode, "random R1-R10");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule